// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides one 32-bit integer by another over several clock cycles. A processor datapath hands it a dividend, a divisor and a mode bit with a one-cycle start pulse. The quotient goes to a LOW result register and the remainder to a HIGH result register. The mode bit is the lowest bit of the divide function code: function code 011010 (bit 0 clear) selects signed division, and 011011 (bit 0 set) selects unsigned division.

Signed operands are first reduced to magnitudes. A restoring shift-subtract core then produces one quotient bit per cycle. At the end the signs are restored: the quotient is truncated toward zero and the remainder follows the dividend. The block never reports overflow, because results simply wrap modulo 2^32. A zero divisor has no architectural meaning. Here it still gives a fixed pair of values, and the block returns to idle on the normal schedule.

Top module: `iter_divider`

## Requirements
- R1: After reset, busy and done are 0 and hi_out and lo_out are both zero.
- R2: A start pulse while the block is idle is accepted, and busy reads 1 in the following cycle. A start pulse while busy is 1 is ignored: the result and its timing belong to the operation already running, and no extra result follows.
- R3: Done is high for exactly one cycle, 38 clock edges after the edge that accepted start. At that same edge busy returns to 0.
- R4: With is_unsigned = 1 (function code 011011), both operands are unsigned, lo_out = floor(dividend / divisor) and hi_out = dividend mod divisor.
- R5: With is_unsigned = 0 (function code 011010), both operands are two's complement. The quotient is truncated toward zero, and it is negative when the operand signs differ.
- R6: In signed mode the remainder is zero or has the sign of the dividend, and its magnitude is less than that of the divisor.
- R7: In signed mode, 0x80000000 divided by 0xFFFFFFFF gives lo_out = 0x80000000 and hi_out = 0, with no overflow indication.
- R8: With a zero divisor in either mode, lo_out = 0xFFFFFFFF and hi_out = dividend, and the block completes on the R3 schedule.
- R9: hi_out and lo_out change only at the edge that raises done, and they hold their values at all other times, including while a new division runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a division |
| is_unsigned | input | 1 | Function code bit 0: 1 = unsigned, 0 = signed |
| dividend | input | 32 | Numerator, sampled with start |
| divisor | input | 32 | Denominator, sampled with start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results update |
| hi_out | output | 32 | Remainder (HIGH register) |
| lo_out | output | 32 | Quotient (LOW register) |

## Verification
Two events can fall in the same cycle: the done pulse that ends one division and a start pulse for the next. The bench raises start in the very cycle it sees done. It then expects busy to rise again in the next cycle, the first results to stay on hi_out and lo_out for the whole second run, and the second results to arrive exactly 38 edges later. A second case lands a start in the middle of a running division and judges that neither the result nor its timing moves.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int DIV_WIDTH   = 32;
  localparam int DIV_LATENCY = 38;

  typedef enum logic {
    MODE_SIGNED   = 1'b0,
    MODE_UNSIGNED = 1'b1
  } div_mode_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int WIDTH = div_pkg::DIV_WIDTH
) (
  input  logic [WIDTH-1:0] num_i,
  input  logic [WIDTH-1:0] den_i,
  input  logic             mode_i,
  output logic [WIDTH-1:0] num_mag_o,
  output logic [WIDTH-1:0] den_mag_o,
  output logic             flip_quo_o,
  output logic             flip_rem_o
);
  import div_pkg::*;

  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  logic num_neg, den_neg, den_zero;

  always_comb begin
    num_neg    = (div_mode_e'(mode_i) == MODE_SIGNED) && num_i[WIDTH-1];
    den_neg    = (div_mode_e'(mode_i) == MODE_SIGNED) && den_i[WIDTH-1];
    den_zero   = (den_i == '0);
    num_mag_o  = magnitude(num_i, num_neg);
    den_mag_o  = magnitude(den_i, den_neg);
    flip_quo_o = (num_neg ^ den_neg) && !den_zero;
    flip_rem_o = num_neg;
  end
endmodule

// File: rtl/div_step_unit.sv
module div_step_unit #(
  parameter int WIDTH = div_pkg::DIV_WIDTH
) (
  input  logic [WIDTH-1:0] part_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH-1:0] den_i,
  output logic [WIDTH-1:0] part_o,
  output logic [WIDTH-1:0] quo_o
);
  localparam int EXT_W = WIDTH + 1;

  function automatic logic [EXT_W-1:0] trial_sub(input logic [EXT_W-1:0] shifted,
                                                 input logic [WIDTH-1:0] den);
    return shifted - {1'b0, den};
  endfunction

  logic [EXT_W-1:0] shifted, diff;
  logic             fits;

  always_comb begin
    shifted = {part_i, quo_i[WIDTH-1]};
    diff    = trial_sub(shifted, den_i);
    fits    = !diff[EXT_W-1];
    part_o  = fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
    quo_o   = {quo_i[WIDTH-2:0], fits};
  end
endmodule

// File: rtl/div_sequencer.sv
module div_sequencer #(
  parameter int ITERS   = div_pkg::DIV_WIDTH,
  parameter int LATENCY = div_pkg::DIV_LATENCY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic accept_o,
  output logic iter_o,
  output logic finish_o
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    accept_o = start_i && !busy_o;
    iter_o   = busy_o && (cnt < CNT_W'(ITERS));
    finish_o = busy_o && (cnt == CNT_W'(LATENCY - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt    <= '0;
    end else begin
      done_o <= finish_o;
      if (accept_o) begin
        busy_o <= 1'b1;
        cnt    <= '0;
      end else if (finish_o) begin
        busy_o <= 1'b0;
      end else if (busy_o) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int WIDTH   = div_pkg::DIV_WIDTH,
  parameter int LATENCY = div_pkg::DIV_LATENCY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_unsigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi_out,
  output logic [WIDTH-1:0] lo_out
);
  function automatic logic [WIDTH-1:0] apply_sign(input logic [WIDTH-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  logic             accept, iter_en, finish;
  logic [WIDTH-1:0] num_mag, den_mag;
  logic             flip_q_in, flip_r_in;
  logic [WIDTH-1:0] part_q, quo_q, den_q;
  logic             flip_q, flip_r;
  logic [WIDTH-1:0] part_nx, quo_nx;

  div_sequencer #(.ITERS(WIDTH), .LATENCY(LATENCY)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .busy_o   (busy),
    .done_o   (done),
    .accept_o (accept),
    .iter_o   (iter_en),
    .finish_o (finish)
  );

  div_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .num_i      (dividend),
    .den_i      (divisor),
    .mode_i     (is_unsigned),
    .num_mag_o  (num_mag),
    .den_mag_o  (den_mag),
    .flip_quo_o (flip_q_in),
    .flip_rem_o (flip_r_in)
  );

  div_step_unit #(.WIDTH(WIDTH)) u_step (
    .part_i (part_q),
    .quo_i  (quo_q),
    .den_i  (den_q),
    .part_o (part_nx),
    .quo_o  (quo_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_q <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      flip_q <= 1'b0;
      flip_r <= 1'b0;
      hi_out <= '0;
      lo_out <= '0;
    end else begin
      if (accept) begin
        part_q <= '0;
        quo_q  <= num_mag;
        den_q  <= den_mag;
        flip_q <= flip_q_in;
        flip_r <= flip_r_in;
      end else if (iter_en) begin
        part_q <= part_nx;
        quo_q  <= quo_nx;
      end
      if (finish) begin
        lo_out <= apply_sign(quo_q, flip_q);
        hi_out <= apply_sign(part_q, flip_r);
      end
    end
  end
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int WIDTH   = 32,
  parameter int LATENCY = 38
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             is_unsigned,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hi_out,
  input logic [WIDTH-1:0] lo_out,
  input logic             accept
);
  logic [15:0]      since_go;
  logic [WIDTH-1:0] cap_a, cap_b;
  logic             cap_u;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_go <= '0;
      cap_a    <= '0;
      cap_b    <= '0;
      cap_u    <= 1'b0;
    end else if (accept) begin
      since_go <= '0;
      cap_a    <= dividend;
      cap_b    <= divisor;
      cap_u    <= is_unsigned;
    end else if (since_go != 16'hFFFF) begin
      since_go <= since_go + 1'b1;
    end
  end

  // R2
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (since_go == 16'(LATENCY)) && !busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  unsigned_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_u && cap_b != '0) |-> (hi_out < cap_b) && ((lo_out * cap_b + hi_out) == cap_a));

  // R6
  rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_u && cap_b != '0 && hi_out != '0) |-> (hi_out[WIDTH-1] == cap_a[WIDTH-1]));

  // R8
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_b == '0) |-> (lo_out == '1) && (hi_out == cap_a));

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(hi_out) && $stable(lo_out));
endmodule

bind iter_divider div_checker #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_div_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .is_unsigned (is_unsigned),
  .dividend    (dividend),
  .divisor     (divisor),
  .busy        (busy),
  .done        (done),
  .hi_out      (hi_out),
  .lo_out      (lo_out),
  .accept      (accept)
);

// File: tb/test_iter_divider.sv
`timescale 1ns/1ps
module test_iter_divider;
  localparam int W   = 32;
  localparam int LAT = 38;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         is_unsigned = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done;
  logic [W-1:0] hi_out, lo_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  iter_divider i_iter_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .is_unsigned(is_unsigned),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .hi_out(hi_out), .lo_out(lo_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Independent model: magnitudes in 64 bits, signs applied afterwards.
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input bit uns,
                       output logic [W-1:0] ehi, output logic [W-1:0] elo);
    logic [63:0] ma, mb, q, r;
    bit na, nb;
    na = !uns && a[W-1];
    nb = !uns && b[W-1];
    ma = na ? 64'(-$signed({1'b1, a})) & 64'hFFFF_FFFF : {32'h0, a};
    mb = nb ? 64'(-$signed({1'b1, b})) & 64'hFFFF_FFFF : {32'h0, b};
    if (na) ma = 64'(33'h1_0000_0000 - {1'b0, a});
    if (nb) mb = 64'(33'h1_0000_0000 - {1'b0, b});
    if (b == '0) begin
      elo = '1;
      ehi = a;
    end else begin
      q = ma / mb;
      r = ma % mb;
      if (na != nb) q = 64'(0) - q;
      if (na) r = 64'(0) - r;
      elo = q[W-1:0];
      ehi = r[W-1:0];
    end
  endtask

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input bit uns);
    start = 1'b1;
    dividend = a;
    divisor = b;
    is_unsigned = uns;
    @(negedge clk);
    start = 1'b0;
  endtask

  // w0: negedges seen since the edge that accepted start, counting that one as 1.
  task automatic wait_done(input int w0, output int lat);
    int w;
    w = w0;
    while (!done && w < LAT + 20) begin
      @(negedge clk);
      w++;
    end
    lat = done ? w - 1 : -1;
  endtask

  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit uns,
                         input string req);
    logic [W-1:0] ehi, elo;
    int lat;
    model(a, b, uns, ehi, elo);
    @(negedge clk);
    issue(a, b, uns);
    check(busy == 1'b1, "R2", "busy after start", 64'(busy), 64'd1);
    wait_done(1, lat);
    check(lat == LAT, "R3", "latency", 64'(lat), 64'(LAT));
    check(busy == 1'b0, "R3", "busy with done", 64'(busy), 64'd0);
    check(lo_out == elo, req, "quotient", 64'(lo_out), 64'(elo));
    check(hi_out == ehi, req, "remainder", 64'(hi_out), 64'(ehi));
    @(negedge clk);
    check(done == 1'b0, "R3", "done one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done", {busy, done}, 64'd0);
    check(hi_out == '0 && lo_out == '0, "R1", "hi/lo", {hi_out, lo_out}, 64'd0);
  endtask

  task automatic t_unsigned();
    run_div(32'd100, 32'd7, 1'b1, "R4");
    run_div(32'hFFFF_FFFF, 32'd3, 1'b1, "R4");
    run_div(32'hFFFF_FFF9, 32'd2, 1'b1, "R4");
    run_div(32'd5, 32'd9, 1'b1, "R4");
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R4");
  endtask

  task automatic t_signed();
    run_div(32'd7, 32'd2, 1'b0, "R5");
    run_div(-32'sd7, 32'd2, 1'b0, "R5");
    run_div(32'd7, -32'sd2, 1'b0, "R6");
    run_div(-32'sd7, -32'sd2, 1'b0, "R6");
    run_div(-32'sd1000003, 32'd97, 1'b0, "R6");
  endtask

  task automatic t_wrap();
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R7");
    check(lo_out == 32'h8000_0000 && hi_out == '0, "R7", "min/-1",
          {hi_out, lo_out}, 64'h0000_0000_8000_0000);
  endtask

  task automatic t_zero();
    run_div(32'h1234_5678, 32'd0, 1'b1, "R8");
    run_div(32'hF000_0001, 32'd0, 1'b0, "R8");
    check(busy == 1'b0, "R8", "idle after zero divisor", 64'(busy), 64'd0);
  endtask

  task automatic t_busy_ignore();
    logic [W-1:0] ehi, elo;
    int lat;
    model(32'd1000, 32'd3, 1'b1, ehi, elo);
    @(negedge clk);
    issue(32'd1000, 32'd3, 1'b1);
    repeat (4) @(negedge clk);
    issue(32'd77, 32'd5, 1'b1);
    wait_done(6, lat);
    check(lat == LAT, "R2", "latency kept under busy start", 64'(lat), 64'(LAT));
    check(lo_out == elo && hi_out == ehi, "R2", "first operands kept",
          {hi_out, lo_out}, {ehi, elo});
    for (int i = 0; i < LAT + 6; i++) begin
      @(negedge clk);
      if (done || busy) break;
    end
    check(done == 1'b0 && busy == 1'b0, "R2", "no second result", {busy, done}, 64'd0);
  endtask

  task automatic t_back_to_back();
    logic [W-1:0] h1, l1, h2, l2;
    int lat;
    bit held;
    model(32'd50, 32'd6, 1'b1, h1, l1);
    model(-32'sd50, 32'd6, 1'b0, h2, l2);
    @(negedge clk);
    issue(32'd50, 32'd6, 1'b1);
    wait_done(1, lat);
    check(lo_out == l1 && hi_out == h1, "R4", "first of pair", {hi_out, lo_out}, {h1, l1});
    issue(-32'sd50, 32'd6, 1'b0);
    check(busy == 1'b1, "R2", "start taken in done cycle", 64'(busy), 64'd1);
    held = 1'b1;
    lat = 0;
    for (int w = 1; w < LAT + 20; w++) begin
      if (done) begin
        lat = w - 1;
        break;
      end
      if (lo_out != l1 || hi_out != h1) held = 1'b0;
      @(negedge clk);
    end
    check(held, "R9", "results held during second run", 64'(held), 64'd1);
    check(lat == LAT, "R3", "back-to-back latency", 64'(lat), 64'(LAT));
    check(lo_out == l2 && hi_out == h2, "R5", "second of pair", {hi_out, lo_out}, {h2, l2});
  endtask

  task automatic t_hold();
    logic [W-1:0] h0, l0;
    h0 = hi_out;
    l0 = lo_out;
    dividend = 32'hDEAD_BEEF;
    divisor = 32'd11;
    repeat (8) @(negedge clk);
    check(hi_out == h0 && lo_out == l0, "R9", "idle hold", {hi_out, lo_out}, {h0, l0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_wrap();
    t_zero();
    t_busy_ignore();
    t_back_to_back();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule